// File: doc/BRIEF.md
# Half-line vertical sync pulse generator

This block drives the active-low vertical sync line through the first-field vertical interval of a 625-line interlaced video timing chain. It holds a 9-bit horizontal position counter that advances on a 7 MHz pixel enable and wraps after 448 counts. It also holds a half-line counter that steps at the two half-line boundaries of every line, at horizontal counts 80 and 304. Each half line inside the sync window starts with a low-going pulse. The pulse is short (equalising) or long (serration), depending on the half-line index.

The pulse low times come from cheap decodes of the horizontal counter, not from dedicated timers. A short pulse ends when bit 4 of the counter falls, 16 counts after the start. A long pulse ends when bits 8..4 match one of two patterns, 208 counts after the start. Whether the pulse is short or long is latched at the half-line boundary, so it cannot change partway through a pulse. The half-line count per frame and the lengths of the three pulse groups are parameters.

Top module: `vsync_halfline_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is `hc`=0, `vc`=0 and `vsync_n`=1.
- R2: `hc` changes only on clock edges where `pix_en` is 1. It then steps by one and goes from 447 back to 0. When `pix_en` is 0, `hc`, `vc` and `vsync_n` all hold.
- R3: `vc` steps by one on the edge where `hc` becomes 80 or 304, going from VC_TOTAL-1 back to 0. It changes at no other time.
- R4: `vsync_n` falls only on the edge where `hc` becomes 80 or 304. It falls on such an edge exactly when the new `vc` value lies in the sync window 0..PRE_CNT+LONG_CNT+POST_CNT-1.
- R5: A short pulse is low while `hc` shows 16 consecutive counts, and `vsync_n` returns high as `hc` becomes 96 or 320.
- R6: A long pulse is low while `hc` shows 208 consecutive counts, and `vsync_n` returns high as `hc` becomes 288 (start at 80) or 64 (start at 304, across the wrap).
- R7: With the defaults, half lines with `vc` 0..5 carry short pulses, `vc` 6..10 carry long pulses, and `vc` 11..15 carry short pulses.
- R8: When `vc` lies outside the sync window, `vsync_n` stays 1 for the whole half line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | 7 MHz pixel enable; all counters advance only when high |
| hc | output | 9 | Horizontal position count, 0..447 |
| vc | output | VC_W | Half-line index, 0..VC_TOTAL-1 |
| vsync_n | output | 1 | Active-low vertical sync |

## Verification
A wrong horizontal count shows at the ports on the very next enabled step, as a non-consecutive `hc` value or a missed wrap. Because the pulse ends are decoded from that count, it also appears within one half line as a wrong pulse length. A corrupt half-line index or short/long choice shows at the next half-line boundary as a pulse of the wrong kind, or as a pulse outside the window. The bench measures each pulse's start position, index and low length against an independently built list of expected pulses. It then runs past the window of the second frame, so a missing or extra pulse is also caught.

// File: rtl/vsync_pkg.sv
package vsync_pkg;

    localparam int HC_W     = 9;
    localparam int H_TOTAL  = 448;
    localparam int HALF_A   = 80;
    localparam int HALF_B   = 304;
    localparam int SHORT_BIT = 4;
    localparam logic [4:0] LONG_END_A = 5'b00100;  // hc 64..79
    localparam logic [4:0] LONG_END_B = 5'b10010;  // hc 288..303

    typedef logic [HC_W-1:0] hc_t;

    typedef enum logic [1:0] {
        PH_HIGH  = 2'd0,
        PH_SHORT = 2'd1,
        PH_LONG  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_SHORT = 2'd1,
        KIND_LONG  = 2'd2
    } kind_e;

    typedef struct packed {
        logic start;       // next count is a half-line boundary
        logic short_done;  // bit 4 falls on this step
        logic long_done;   // next count matches a long-pulse end pattern
    } hevt_t;

    function automatic hc_t hc_step(input hc_t cur);
        return (cur == hc_t'(H_TOTAL - 1)) ? '0 : cur + hc_t'(1);
    endfunction

    function automatic logic is_half_start(input hc_t v);
        return (v == hc_t'(HALF_A)) || (v == hc_t'(HALF_B));
    endfunction

    // Full five-bit compare: a partial one would also hit at the 80 boundary.
    function automatic logic long_end_match(input hc_t v);
        return (v[8:4] == LONG_END_A) || (v[8:4] == LONG_END_B);
    endfunction

endpackage

// File: rtl/vsync_hcount.sv
module vsync_hcount
    import vsync_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pix_en,
    output hc_t   hc,
    output hevt_t evt
);
    hc_t hc_q;
    hc_t hc_nxt;

    always_comb begin
        hc_nxt         = hc_step(hc_q);
        evt.start      = is_half_start(hc_nxt);
        evt.short_done = hc_q[SHORT_BIT] & ~hc_nxt[SHORT_BIT];
        evt.long_done  = long_end_match(hc_nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hc_q <= '0;
        end else if (pix_en) begin
            hc_q <= hc_nxt;
        end
    end

    assign hc = hc_q;
endmodule

// File: rtl/vsync_vcount.sv
module vsync_vcount
    import vsync_pkg::*;
#(
    parameter int VC_TOTAL = 1250,
    parameter int PRE_CNT  = 6,
    parameter int LONG_CNT = 5,
    parameter int POST_CNT = 5,
    parameter int VC_W     = $clog2(VC_TOTAL)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pix_en,
    input  logic            start,
    output logic [VC_W-1:0] vc,
    output kind_e           kind_nxt
);
    localparam logic [VC_W-1:0] VC_LAST    = VC_W'(VC_TOTAL - 1);
    localparam logic [VC_W-1:0] LONG_FIRST = VC_W'(PRE_CNT);
    localparam logic [VC_W-1:0] POST_FIRST = VC_W'(PRE_CNT + LONG_CNT);
    localparam logic [VC_W-1:0] WIN_END    = VC_W'(PRE_CNT + LONG_CNT + POST_CNT);

    logic [VC_W-1:0] vc_q;
    logic [VC_W-1:0] vc_nxt;

    always_comb begin
        vc_nxt = (vc_q == VC_LAST) ? '0 : vc_q + 1'b1;
        if (vc_nxt >= WIN_END) begin
            kind_nxt = KIND_NONE;
        end else if (vc_nxt >= POST_FIRST) begin
            kind_nxt = KIND_SHORT;
        end else if (vc_nxt >= LONG_FIRST) begin
            kind_nxt = KIND_LONG;
        end else begin
            kind_nxt = KIND_SHORT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vc_q <= '0;
        end else if (pix_en && start) begin
            vc_q <= vc_nxt;
        end
    end

    assign vc = vc_q;
endmodule

// File: rtl/vsync_pulse_fsm.sv
module vsync_pulse_fsm
    import vsync_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pix_en,
    input  hevt_t evt,
    input  kind_e kind,
    output logic  vsync_n
);
    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_HIGH;
        end else if (pix_en) begin
            if (evt.start) begin
                case (kind)
                    KIND_SHORT: phase_q <= PH_SHORT;
                    KIND_LONG:  phase_q <= PH_LONG;
                    default:    phase_q <= PH_HIGH;
                endcase
            end else if (phase_q == PH_SHORT && evt.short_done) begin
                phase_q <= PH_HIGH;
            end else if (phase_q == PH_LONG && evt.long_done) begin
                phase_q <= PH_HIGH;
            end
        end
    end

    assign vsync_n = (phase_q == PH_HIGH);
endmodule

// File: rtl/vsync_halfline_gen.sv
module vsync_halfline_gen
    import vsync_pkg::*;
#(
    parameter int VC_TOTAL = 1250,
    parameter int PRE_CNT  = 6,
    parameter int LONG_CNT = 5,
    parameter int POST_CNT = 5,
    parameter int VC_W     = $clog2(VC_TOTAL)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pix_en,
    output logic [8:0]      hc,
    output logic [VC_W-1:0] vc,
    output logic            vsync_n
);
    hevt_t evt;
    kind_e kind_nxt;
    hc_t   hc_w;

    vsync_hcount u_hcount (
        .clk    (clk),
        .rst    (rst),
        .pix_en (pix_en),
        .hc     (hc_w),
        .evt    (evt)
    );

    vsync_vcount #(
        .VC_TOTAL (VC_TOTAL),
        .PRE_CNT  (PRE_CNT),
        .LONG_CNT (LONG_CNT),
        .POST_CNT (POST_CNT),
        .VC_W     (VC_W)
    ) u_vcount (
        .clk      (clk),
        .rst      (rst),
        .pix_en   (pix_en),
        .start    (evt.start),
        .vc       (vc),
        .kind_nxt (kind_nxt)
    );

    vsync_pulse_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .pix_en  (pix_en),
        .evt     (evt),
        .kind    (kind_nxt),
        .vsync_n (vsync_n)
    );

    assign hc = hc_w;
endmodule

// File: rtl/vsync_halfline_chk.sv
module vsync_halfline_chk #(
    parameter int VC_TOTAL = 1250,
    parameter int VC_W     = 11,
    parameter int WIN_END  = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            pix_en,
    input logic [8:0]      hc,
    input logic [VC_W-1:0] vc,
    input logic            vsync_n
);
    logic [VC_W-1:0] vc_inc;
    logic [8:0]      low_cnt;

    always_comb vc_inc = (vc == VC_W'(VC_TOTAL - 1)) ? '0 : vc + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
        end else if (pix_en) begin
            low_cnt <= vsync_n ? 9'd0 : low_cnt + 9'd1;
        end
    end

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (hc == 9'd0 && vc == '0 && vsync_n));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> ($stable(hc) && $stable(vc) && $stable(vsync_n)));

    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (pix_en && hc == 9'd447) |=> (hc == 9'd0));

    a_r3_vc_step: assert property (@(posedge clk) disable iff (rst)
        (pix_en && (hc == 9'd79 || hc == 9'd303)) |=> (vc == $past(vc_inc)));

    a_r4_fall_at_boundary: assert property (@(posedge clk) disable iff (rst)
        $fell(vsync_n) |-> (hc == 9'd80 || hc == 9'd304));

    a_r6_low_len: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync_n) |-> (low_cnt == 9'd16 || low_cnt == 9'd208));

    a_r8_window: assert property (@(posedge clk) disable iff (rst)
        !vsync_n |-> (vc < VC_W'(WIN_END)));
endmodule

bind vsync_halfline_gen vsync_halfline_chk #(
    .VC_TOTAL (VC_TOTAL),
    .VC_W     (VC_W),
    .WIN_END  (PRE_CNT + LONG_CNT + POST_CNT)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pix_en  (pix_en),
    .hc      (hc),
    .vc      (vc),
    .vsync_n (vsync_n)
);

// File: tb/vsync_halfline_gen_test.sv
`timescale 1ns/1ps
module vsync_halfline_gen_test;
    localparam int VC_T  = 40;
    localparam int VC_W  = $clog2(VC_T);
    localparam int WIN   = 16;
    localparam int HALFS = VC_T + WIN;      // pulses expected over k = 1..HALFS
    localparam int RUN_HALFS = HALFS + 5;   // observe beyond the window

    typedef struct { int vc; int hc; int len; } pulse_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pix_en = 1'b0;
    logic run = 1'b0;
    logic [8:0] hc;
    logic [VC_W-1:0] vc;
    logic vsync_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int halfs_seen = 0;
    bit timeout = 0;
    pulse_t expq[$];

    vsync_halfline_gen #(.VC_TOTAL(VC_T)) uut (
        .clk(clk), .rst(rst), .pix_en(pix_en),
        .hc(hc), .vc(vc), .vsync_n(vsync_n)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: expected pulses from the requirements (R4, R5, R6, R7).
    task automatic load_expected();
        for (int k = 1; k <= HALFS; k++) begin
            pulse_t p;
            p.vc = k % VC_T;
            p.hc = (k % 2 == 1) ? 80 : 304;
            if (p.vc < WIN) begin
                p.len = (p.vc >= 6 && p.vc <= 10) ? 208 : 16;
                expq.push_back(p);
            end
        end
    endtask

    // Enable pattern: two of every three cycles while running.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) timeout <= 1'b1;
        pix_en <= run && (cyc % 3 != 2);
    end

    // Monitor / scoreboard.
    int fall_hc = 0;
    int fall_vc = 0;
    logic prev_vs = 1'b1;
    int prev_hc = 0;
    int prev_vc = 0;
    always @(negedge clk) begin
        if (!rst && run) begin
            if (hc != 9'(prev_hc)) begin
                check(int'(hc) == (prev_hc + 1) % 448, "R2 hc step", int'(hc), (prev_hc + 1) % 448);
            end
            if (int'(vc) != prev_vc) begin
                halfs_seen++;
                check(hc == 9'd80 || hc == 9'd304, "R3 vc step position", int'(hc), 80);
                check(int'(vc) == (prev_vc + 1) % VC_T, "R3 vc value", int'(vc), (prev_vc + 1) % VC_T);
            end
            if (prev_vs && !vsync_n) begin
                fall_hc = int'(hc);
                fall_vc = int'(vc);
            end
            if (!prev_vs && vsync_n) begin
                int len;
                len = (int'(hc) + 448 - fall_hc) % 448;
                if (expq.size() == 0) begin
                    check(0, "R8 unexpected pulse", fall_vc, -1);
                end else begin
                    pulse_t e;
                    e = expq.pop_front();
                    check(fall_vc == e.vc, "R7 pulse index", fall_vc, e.vc);
                    check(fall_hc == e.hc, "R4 pulse start", fall_hc, e.hc);
                    check(len == e.len, (e.len == 16) ? "R5 short length" : "R6 long length", len, e.len);
                end
            end
            prev_vs = vsync_n;
            prev_hc = int'(hc);
            prev_vc = int'(vc);
        end
    end

    initial begin
        load_expected();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(hc == 9'd0, "R1 reset hc", int'(hc), 0);
        check(vc == '0, "R1 reset vc", int'(vc), 0);
        check(vsync_n == 1'b1, "R1 reset vsync_n", int'(vsync_n), 1);
        repeat (8) @(negedge clk);
        check(hc == 9'd0 && vc == '0 && vsync_n, "R2 hold without enable", int'(hc), 0);
        run = 1'b1;
        wait (halfs_seen >= RUN_HALFS || timeout);
        if (timeout) check(0, "watchdog", halfs_seen, RUN_HALFS);
        check(expq.size() == 0, "R7 all pulses seen", expq.size(), 0);
        check(vsync_n == 1'b1, "R8 high outside window", int'(vsync_n), 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule